// File: doc/BRIEF.md
# Shadow Store and Recall Controller for a Byte Memory

This block pairs a fast volatile byte array with a nonvolatile shadow array of the same size and moves the whole image between them. A store copies every volatile byte into the shadow. A recall copies the shadow back into the volatile array. A store can be started in three ways: a power-fail indication, a software strobe, or an external agent pulling the shared open-drain busy line low. A recall runs on its own when reset is released, which models power-up. Software can also request a recall with a strobe. The power sensing and the software unlock sequence sit outside this block. They reach it only as plain request inputs.

The host reaches the volatile array through an asynchronous-style byte port with three active-low controls: chip enable, write enable and output enable. While a transfer runs, the port is shut. Reads leave the data bus undriven and writes are dropped. The busy line is pulled low by the block for as long as a store lasts, so other agents on the board can observe it. A saturating counter reports how many stores have completed since reset.

The array depth is set by `ADDR_W`. The default is kept small, and the full-size part uses `ADDR_W = 15`, which gives 32,768 bytes. The data width is set by `DATA_W`, which defaults to 8.

Top module: `nvs_shadow_ctrl`

## Requirements
- R1: Releasing reset starts a recall at once. The recall copies every shadow byte into the volatile array, and reset does not clear either array, so host data saved by a store is readable again after a reset.
- R2: A host write (ce_n low, we_n low) stores dq_i at the address captured when ce_n fell. A host read (ce_n low, oe_n low, we_n high) raises dq_oe_o and presents on dq_o the byte at the current addr.
- R3: dq_oe_o is low whenever oe_n is high or we_n is low, even with ce_n low.
- R4: A one-cycle sw_store_i pulse starts a store in the next cycle. hsb_n is then held low for exactly 2^ADDR_W cycles, during which every volatile byte is copied into the shadow.
- R5: If another agent drives hsb_n low while no store is running, a store starts. It is triggered by the high-to-low transition of the line.
- R6: A rising edge on pwr_fail_i starts exactly one store. Keeping pwr_fail_i high afterwards starts no further store.
- R7: A one-cycle sw_recall_i pulse copies the whole shadow array into the volatile array.
- R8: While a store or recall runs, dq_oe_o stays low and host writes leave the volatile array unchanged.
- R9: A store request that arrives during a store has no effect. The running store keeps its length and the counter rises by one only.
- R10: A store request that arrives during a recall, or in the same cycle as a software recall, is held. The store then begins in the cycle after the recall finishes. This includes the recall that follows reset.
- R11: store_count_o is 0 after reset and rises by one at the end of each store. It saturates at 2^CNT_W-1.
- R12: When no store is running and no other agent drives it, hsb_n reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release models power-up |
| ce_n | input | 1 | Host chip enable, active low |
| we_n | input | 1 | Host write enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| addr | input | ADDR_W | Host byte address |
| dq_i | input | DATA_W | Host write data |
| dq_o | output | DATA_W | Host read data |
| dq_oe_o | output | 1 | Read data valid; the bus driver enable |
| hsb_n | inout | 1 | Open-drain store-busy line with internal pull-up |
| pwr_fail_i | input | 1 | Power-fail indication, level; its rising edge requests a store |
| sw_store_i | input | 1 | Software store strobe |
| sw_recall_i | input | 1 | Software recall strobe |
| store_count_o | output | CNT_W | Saturating count of completed stores |

## Verification
The hardest case to reach from the ports is a store request that collides with the recall the block starts by itself at power-up. The bench releases reset and, on the same falling clock edge, pulses the software store strobe. It then counts the cycles in which the busy line is high and the cycles in which it is low. This shows that the whole recall ran first and the held store followed with no gap. A second hard case is a request arriving in the middle of a store. The bench issues a read, a write and a second store strobe after the first store has begun. It then measures the remaining busy time and reads back the whole array.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [1:0] {
        XF_IDLE   = 2'd0,
        XF_STORE  = 2'd1,
        XF_RECALL = 2'd2
    } xfer_e;

endpackage

// File: rtl/nvs_mem.sv
module nvs_mem #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    // Contents survive reset on purpose: the shadow holds the saved image.
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/nvs_host_port.sv
module nvs_host_port #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gate,
    output logic [ADDR_W-1:0] waddr_o,
    output logic              wr_en_o,
    output logic              rd_oe_o
);
    typedef struct packed {
        logic              ce_prev;
        logic [ADDR_W-1:0] alat;
    } port_t;

    port_t port_d, port_q;
    logic  ce_fall;

    always_comb begin
        port_d         = port_q;
        ce_fall        = !ce_n && port_q.ce_prev;
        port_d.ce_prev = ce_n;
        if (ce_fall) begin
            port_d.alat = addr;
        end
        waddr_o = ce_fall ? addr : port_q.alat;
        wr_en_o = !ce_n && !we_n && !gate;
        rd_oe_o = !ce_n && !oe_n && we_n && !gate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q.ce_prev <= 1'b1;
            port_q.alat    <= '0;
        end else begin
            port_q <= port_d;
        end
    end

    // R2
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && port_q.ce_prev) |=> (port_q.alat == $past(addr)));

    // R3
    rd_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_oe_o |-> !wr_en_o));

endmodule

// File: rtl/nvs_xfer_ctrl.sv
module nvs_xfer_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_fail_i,
    input  logic              sw_store_i,
    input  logic              sw_recall_i,
    input  logic              line_low_i,
    output xfer_e             state_o,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o
);
    localparam logic [ADDR_W-1:0] LAST    = '1;
    localparam logic [CNT_W-1:0]  CNT_MAX = '1;

    typedef struct packed {
        xfer_e             state;
        logic [ADDR_W-1:0] ptr;
        logic [CNT_W-1:0]  cnt;
        logic              pend;
        logic              pf;
        logic              line;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  hw_req, st_req, at_last;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.pf   = pwr_fail_i;
        ctrl_d.line = line_low_i;
        hw_req      = line_low_i && !ctrl_q.line && (ctrl_q.state != XF_STORE);
        st_req      = sw_store_i || (pwr_fail_i && !ctrl_q.pf) || hw_req;
        at_last     = (ctrl_q.ptr == LAST);

        unique case (ctrl_q.state)
            XF_IDLE: begin
                if (sw_recall_i) begin
                    ctrl_d.state = XF_RECALL;
                    ctrl_d.ptr   = '0;
                    ctrl_d.pend  = st_req;
                end else if (st_req) begin
                    ctrl_d.state = XF_STORE;
                    ctrl_d.ptr   = '0;
                end
            end
            XF_RECALL: begin
                ctrl_d.ptr = ctrl_q.ptr + 1'b1;
                if (st_req) begin
                    ctrl_d.pend = 1'b1;
                end
                if (at_last) begin
                    ctrl_d.pend  = 1'b0;
                    ctrl_d.ptr   = '0;
                    ctrl_d.state = (ctrl_q.pend || st_req) ? XF_STORE : XF_IDLE;
                end
            end
            XF_STORE: begin
                ctrl_d.ptr = ctrl_q.ptr + 1'b1;
                if (at_last) begin
                    ctrl_d.state = XF_IDLE;
                    ctrl_d.ptr   = '0;
                    if (ctrl_q.cnt != CNT_MAX) begin
                        ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                ctrl_d.state = XF_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.state <= XF_RECALL;
            ctrl_q.ptr   <= '0;
            ctrl_q.cnt   <= '0;
            ctrl_q.pend  <= 1'b0;
            ctrl_q.pf    <= 1'b0;
            ctrl_q.line  <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state_o = ctrl_q.state;
    assign ptr_o   = ctrl_q.ptr;
    assign cnt_o   = ctrl_q.cnt;

    // R4
    store_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == XF_STORE && ctrl_q.ptr != LAST)
        |=> (ctrl_q.state == XF_STORE && ctrl_q.ptr == $past(ctrl_q.ptr) + 1'b1));

    // R9
    store_ends_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == XF_STORE && ctrl_q.ptr == LAST) |=> (ctrl_q.state == XF_IDLE));

    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.cnt == CNT_MAX) |=> (ctrl_q.cnt == CNT_MAX));

    // R11
    cnt_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q.state == XF_STORE && ctrl_q.ptr == LAST) |=> $stable(ctrl_q.cnt));

    // R10
    pend_to_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.state == XF_RECALL && ctrl_q.ptr == LAST && ctrl_q.pend)
        |=> (ctrl_q.state == XF_STORE && ctrl_q.ptr == '0));

endmodule

// File: rtl/nvs_shadow_ctrl.sv
module nvs_shadow_ctrl
    import nvs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o,
    inout  wire               hsb_n,
    input  logic              pwr_fail_i,
    input  logic              sw_store_i,
    input  logic              sw_recall_i,
    output logic [CNT_W-1:0]  store_count_o
);
    xfer_e             state;
    logic [ADDR_W-1:0] ptr;
    logic              busy, storing, recalling, line_low;
    logic [ADDR_W-1:0] host_waddr;
    logic              host_we, host_rd;
    logic              vol_we;
    logic [ADDR_W-1:0] vol_waddr, vol_raddr;
    logic [DATA_W-1:0] vol_wdata, vol_rdata, sh_rdata;

    assign storing   = (state == XF_STORE);
    assign recalling = (state == XF_RECALL);
    assign busy      = storing || recalling;

    // Open-drain busy line: driven low during a store, otherwise released.
    pullup (hsb_n);
    assign hsb_n    = storing ? 1'b0 : 1'bz;
    assign line_low = (hsb_n == 1'b0);

    nvs_xfer_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_fail_i  (pwr_fail_i),
        .sw_store_i  (sw_store_i),
        .sw_recall_i (sw_recall_i),
        .line_low_i  (line_low),
        .state_o     (state),
        .ptr_o       (ptr),
        .cnt_o       (store_count_o)
    );

    nvs_host_port #(.ADDR_W(ADDR_W)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .gate    (busy),
        .waddr_o (host_waddr),
        .wr_en_o (host_we),
        .rd_oe_o (host_rd)
    );

    always_comb begin
        vol_raddr = busy ? ptr : addr;
        if (recalling) begin
            vol_we    = 1'b1;
            vol_waddr = ptr;
            vol_wdata = sh_rdata;
        end else begin
            vol_we    = host_we;
            vol_waddr = host_waddr;
            vol_wdata = dq_i;
        end
    end

    nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_vol (
        .clk   (clk),
        .we    (vol_we),
        .waddr (vol_waddr),
        .wdata (vol_wdata),
        .raddr (vol_raddr),
        .rdata (vol_rdata)
    );

    nvs_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk   (clk),
        .we    (storing),
        .waddr (ptr),
        .wdata (vol_rdata),
        .raddr (ptr),
        .rdata (sh_rdata)
    );

    assign dq_o    = vol_rdata;
    assign dq_oe_o = host_rd;

    // R8
    no_host_write_in_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        storing |-> !vol_we);

    // R8
    no_read_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dq_oe_o);

    // R4
    busy_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        storing |-> line_low);

endmodule

// File: tb/nvs_shadow_ctrl_tb.sv
module nvs_shadow_ctrl_tb;
    localparam int AW    = 6;
    localparam int DW    = 8;
    localparam int CW    = 3;
    localparam int DEPTH = 1 << AW;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe_o;
    logic          pwr_fail = 1'b0, sw_store = 1'b0, sw_recall = 1'b0;
    logic [CW-1:0] store_count;
    logic          ext_pull = 1'b0;
    wire           hsb_line;

    assign hsb_line = ext_pull ? 1'b0 : 1'bz;

    always #2 clk = ~clk;

    nvs_shadow_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .we_n          (we_n),
        .oe_n          (oe_n),
        .addr          (addr),
        .dq_i          (dq_i),
        .dq_o          (dq_o),
        .dq_oe_o       (dq_oe_o),
        .hsb_n         (hsb_line),
        .pwr_fail_i    (pwr_fail),
        .sw_store_i    (sw_store),
        .sw_recall_i   (sw_recall),
        .store_count_o (store_count)
    );

    logic [DW-1:0] vol_m [DEPTH];
    logic [DW-1:0] sh_m  [DEPTH];
    int exp_cnt = 0;
    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input int d);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        addr = AW'(a); dq_i = DW'(d);
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic host_rd(input int a, output int d, output int oe);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
        #1;
        d  = int'(dq_o);
        oe = int'(dq_oe_o);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < DEPTH; i++) begin
            host_wr(i, (i * 37 + seed) & 8'hFF);
            vol_m[i] = DW'((i * 37 + seed) & 8'hFF);
        end
    endtask

    task automatic check_all(input string req);
        int d, oe, bad;
        bad = 0;
        for (int i = 0; i < DEPTH; i++) begin
            host_rd(i, d, oe);
            if (oe != 1 || d != int'(vol_m[i])) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic count_low(output int n);
        n = 0;
        while (hsb_line == 1'b0 && n < 5000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        while (hsb_line == 1'b1 && n < 5000) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic sw_store_pulse();
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0; #1;
    endtask

    task automatic note_store();
        exp_cnt = (exp_cnt < CMAX) ? exp_cnt + 1 : CMAX;
        for (int i = 0; i < DEPTH; i++) sh_m[i] = vol_m[i];
    endtask

    task automatic power_cycle();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_cnt = 0;
        repeat (DEPTH + 2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = sh_m[i];
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b0; oe_n = 1'b0;
        #1;
        check("R8 read gated during power-up recall", int'(dq_oe_o), 0);
        check("R11 count after reset", int'(store_count), 0);
        check("R12 idle line high", int'(hsb_line), 1);
        ce_n = 1'b1; oe_n = 1'b1;
        repeat (DEPTH + 2) @(negedge clk);
    endtask

    task automatic t_rw();
        fill(5);
        check_all("R2 write then read all bytes");
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 3; #1;
        check("R3 oe_n high", int'(dq_oe_o), 0);
        oe_n = 1'b0; we_n = 1'b0; dq_i = vol_m[3]; #1;
        check("R3 we_n low", int'(dq_oe_o), 0);
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_capture();
        int d, oe;
        @(negedge clk); ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; addr = 10;
        @(negedge clk); addr = 20; we_n = 1'b0; dq_i = 8'hA5;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        vol_m[10] = 8'hA5;
        host_rd(10, d, oe);
        check("R2 captured address written", d, 8'hA5);
        host_rd(20, d, oe);
        check("R2 pin address untouched", d, int'(vol_m[20]));
    endtask

    task automatic t_store_recall();
        int n;
        sw_store_pulse();
        count_low(n);
        check("R4 busy length", n, DEPTH);
        note_store();
        check("R11 count after store", int'(store_count), exp_cnt);
        fill(91);
        @(negedge clk); sw_recall = 1'b1;
        @(negedge clk); sw_recall = 1'b0;
        repeat (DEPTH + 2) @(negedge clk);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = sh_m[i];
        check_all("R7 software recall restores image");
    endtask

    task automatic t_gate();
        int n;
        host_wr(3, 8'h3C); vol_m[3] = 8'h3C;
        @(negedge clk); sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = 7; #1;
        check("R8 read gated during store", int'(dq_oe_o), 0);
        @(negedge clk); oe_n = 1'b1; we_n = 1'b0; addr = 3; dq_i = 8'hC3;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; sw_store = 1'b1;
        @(negedge clk); sw_store = 1'b0; #1;
        count_low(n);
        check("R9 store length not extended", n, DEPTH - 3);
        note_store();
        check("R9 count rises once", int'(store_count), exp_cnt);
        check_all("R8 write during store ignored");
    endtask

    task automatic t_ext();
        int n;
        fill(17);
        @(negedge clk); ext_pull = 1'b1;
        @(negedge clk); ext_pull = 1'b0; #1;
        count_low(n);
        check("R5 external request store length", n, DEPTH);
        note_store();
        check("R12 line released after store", int'(hsb_line), 1);
        fill(200);
        power_cycle();
        check_all("R1 image restored after reset");
    endtask

    task automatic t_pwrfail();
        int n, hi;
        fill(44);
        @(negedge clk); pwr_fail = 1'b1;
        @(negedge clk); #1;
        count_low(n);
        check("R6 power-fail store length", n, DEPTH);
        note_store();
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
            if (hsb_line == 1'b1) hi++;
        end
        check("R6 held level does not restart", hi, 10);
        check("R6 count", int'(store_count), exp_cnt);
        pwr_fail = 1'b0;
    endtask

    task automatic t_priority();
        int hi, lo;
        fill(123);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; sw_store = 1'b1;
        exp_cnt = 0;
        @(negedge clk); sw_store = 1'b0; #1;
        count_high(hi);
        count_low(lo);
        check("R10 recall before held store (high)", hi, DEPTH - 1);
        check("R10 held store length", lo, DEPTH);
        for (int i = 0; i < DEPTH; i++) vol_m[i] = sh_m[i];
        note_store();
        check_all("R10 data after recall then store");
        @(negedge clk); sw_recall = 1'b1; sw_store = 1'b1;
        @(negedge clk); sw_recall = 1'b0; sw_store = 1'b0; #1;
        count_high(hi);
        count_low(lo);
        check("R10 same-cycle recall first", hi, DEPTH);
        check("R10 same-cycle store after", lo, DEPTH);
        note_store();
        check("R11 count after two stores", int'(store_count), exp_cnt);
    endtask

    task automatic t_saturate();
        int n;
        for (int k = 0; k < 7; k++) begin
            sw_store_pulse();
            count_low(n);
            note_store();
            check("R11 saturating count", int'(store_count), exp_cnt);
        end
        check("R11 saturated value", int'(store_count), CMAX);
    endtask

    initial begin
        t_reset();
        t_rw();
        t_capture();
        t_store_recall();
        t_gate();
        t_ext();
        t_pwrfail();
        t_priority();
        t_saturate();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule